// File: doc/BRIEF.md
# Pixel Coordinate Address Generator

This block turns a pixel position into the byte address of that pixel inside a frame buffer. A scan-out or drawing engine uses it. Each request carries the buffer base address and the pixel position, given either as an x/y coordinate pair or as a linear pixel index. Four run-time configuration inputs shape the result:

- the number of address bits given to x;
- the number of address bits given to y;
- the pixel size in bytes;
- the addressing mode.

In coordinate mode, x and y are masked to their field widths. Y is then placed directly above x, and the packed value is scaled by the pixel size. In linear mode, the index is scaled by the pixel size. In both modes the scaled offset is added to the base.

Requests enter on a valid/ready port and results leave on a valid/ready port. The output stage is a single register. A request is taken when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty or its current result is being taken in the same cycle, so one request per cycle flows when the consumer keeps `out_ready` high. When the consumer holds `out_ready` low with a result pending, the result stays fixed and `in_ready` drops. The configuration inputs are sampled together with the request.

Top module: `pix_addr_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_seq`=0, `out_addr` = base + (((y << Nc) | x) × bytes), where Nc is `cfg_xbits` limited to COORD_W (16).
- R3: In coordinate mode, x bits at or above position Nc and y bits at or above position Mc have no effect on `out_addr`. Mc is `cfg_ybits` limited to COORD_W.
- R4: With `cfg_seq`=1, `out_addr` = base + `in_index` × bytes, and the x and y inputs are ignored.
- R5: The pixel size in bytes follows `cfg_bpp`: 0 or 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes, and 4 through 15 give 4 bytes.
- R6: A result is valid on the first rising edge after its request is accepted. With `out_ready` held high, a new request is accepted every cycle.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. Across each such cycle, `out_valid` stays 1 and `out_addr` does not change.
- R8: Field widths `cfg_xbits` or `cfg_ybits` above 16 act as 16. A width of 0 removes that coordinate from the address.
- R9: The address sum wraps modulo 2^ADDR_W (2^32).
- R10: With Nc=9, Mc=8 and 2-byte pixels in coordinate mode, pixel (250,110) at base 0x08000000 gives 0x0801B9F4. Pixel (511,255) gives 0x0803FFFE, the last pixel of a 256 KiB frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_xbits | input | 8 | Address bits given to x (N) |
| cfg_ybits | input | 8 | Address bits given to y (M) |
| cfg_bpp | input | 4 | Bytes per pixel code |
| cfg_seq | input | 1 | 1 = linear index mode, 0 = coordinate mode |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_base | input | 32 | Frame buffer base byte address |
| in_x | input | 16 | X coordinate |
| in_y | input | 16 | Y coordinate |
| in_index | input | 32 | Linear pixel index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Pixel byte address |

## Verification
Every address is due in the cycle after the rising edge that accepts its request, and stays there until the edge at which `out_ready` is high. `in_ready` responds to `out_ready` in the same cycle, through logic only. The bench drives inputs at the falling edge and evaluates both handshakes 2 ns later, so it sees the values that the next rising edge will act on. It queues one expected address per accepted request and compares it at the output handshake. Any edge that follows an acceptance must show `out_valid`, and any stalled cycle must leave `out_addr` unchanged on the next sample.

// File: rtl/pag_pkg.sv
package pag_pkg;
  localparam int CFG_W_BITS = 8;
  localparam int BPP_CODE_W = 4;

  typedef enum logic {
    MODE_XY  = 1'b0,
    MODE_SEQ = 1'b1
  } pag_mode_e;

  typedef struct packed {
    logic [CFG_W_BITS-1:0] xbits;
    logic [CFG_W_BITS-1:0] ybits;
    logic [BPP_CODE_W-1:0] bpp;
    pag_mode_e             mode;
  } pag_cfg_t;
endpackage

// File: rtl/pag_bpp_norm.sv
module pag_bpp_norm #(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] bpp_code,
  output logic [1:0]        byte_shift
);
  always_comb begin
    if (bpp_code <= CODE_W'(1))      byte_shift = 2'd0;
    else if (bpp_code == CODE_W'(2)) byte_shift = 2'd1;
    else                             byte_shift = 2'd2;
  end

  always_comb begin
    p_shift_legal_r5: assert (byte_shift != 2'd3)
      else $error("byte shift out of range");
  end
endmodule

// File: rtl/pag_xy_pack.sv
module pag_xy_pack #(
  parameter int COORD_W = 16,
  parameter int WB_W    = 8,
  localparam int OFF_W  = 2 * COORD_W,
  localparam int SH_W   = $clog2(COORD_W + 1)
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [WB_W-1:0]    xbits,
  input  logic [WB_W-1:0]    ybits,
  output logic [OFF_W-1:0]   offset
);
  logic [SH_W-1:0]    nx, ny;
  logic [COORD_W-1:0] x_keep, y_keep;
  logic [OFF_W-1:0]   y_wide;

  always_comb begin
    nx = (xbits > WB_W'(COORD_W)) ? SH_W'(COORD_W) : SH_W'(xbits);
    ny = (ybits > WB_W'(COORD_W)) ? SH_W'(COORD_W) : SH_W'(ybits);
  end

  for (genvar i = 0; i < COORD_W; i++) begin : g_mask
    assign x_keep[i] = x[i] & (SH_W'(i) < nx);
    assign y_keep[i] = y[i] & (SH_W'(i) < ny);
  end

  assign y_wide = OFF_W'(y_keep);
  assign offset = (y_wide << nx) | OFF_W'(x_keep);

  always_comb begin
    if ((32'(nx) + 32'(ny)) < OFF_W) begin
      p_pack_bound_r3: assert ((offset >> (32'(nx) + 32'(ny))) == '0)
        else $error("packed offset exceeds field widths");
    end
  end
endmodule

// File: rtl/pag_scale_add.sv
module pag_scale_add #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        byte_shift,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] off_a;
  logic [ADDR_W-1:0] scaled;

  assign off_a  = ADDR_W'(offset);
  assign scaled = off_a << byte_shift;
  assign addr   = base + scaled;
endmodule

// File: rtl/pag_out_stage.sv
module pag_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_valid,
  output logic         acc_ready,
  input  logic [W-1:0] d,
  output logic         q_valid,
  input  logic         q_ready,
  output logic [W-1:0] q
);
  logic take;

  assign acc_ready = !q_valid || q_ready;
  assign take      = acc_valid && acc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_valid <= 1'b0;
    else if (take)    q_valid <= 1'b1;
    else if (q_ready) q_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) q <= d;
  end

  p_accept_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> q_valid)
    else $error("accepted request produced no result");

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready && !acc_valid) |=> !q_valid)
    else $error("taken result not cleared");

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q)))
    else $error("result changed while stalled");

  p_block_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |-> !acc_ready)
    else $error("ready high while stalled");
endmodule

// File: rtl/pix_addr_gen.sv
module pix_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 16,
  localparam int OFF_W  = 2 * COORD_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [pag_pkg::CFG_W_BITS-1:0]  cfg_xbits,
  input  logic [pag_pkg::CFG_W_BITS-1:0]  cfg_ybits,
  input  logic [pag_pkg::BPP_CODE_W-1:0]  cfg_bpp,
  input  logic                            cfg_seq,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [ADDR_W-1:0]               in_base,
  input  logic [COORD_W-1:0]              in_x,
  input  logic [COORD_W-1:0]              in_y,
  input  logic [OFF_W-1:0]                in_index,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [ADDR_W-1:0]               out_addr
);
  import pag_pkg::*;

  pag_cfg_t          cfg;
  logic [1:0]        byte_shift;
  logic [OFF_W-1:0]  xy_off;
  logic [OFF_W-1:0]  sel_off;
  logic [ADDR_W-1:0] next_addr;

  assign cfg.xbits = cfg_xbits;
  assign cfg.ybits = cfg_ybits;
  assign cfg.bpp   = cfg_bpp;
  assign cfg.mode  = cfg_seq ? MODE_SEQ : MODE_XY;

  pag_bpp_norm #(.CODE_W(BPP_CODE_W)) u_bpp (
    .bpp_code   (cfg.bpp),
    .byte_shift (byte_shift)
  );

  pag_xy_pack #(.COORD_W(COORD_W), .WB_W(CFG_W_BITS)) u_pack (
    .x      (in_x),
    .y      (in_y),
    .xbits  (cfg.xbits),
    .ybits  (cfg.ybits),
    .offset (xy_off)
  );

  assign sel_off = (cfg.mode == MODE_SEQ) ? in_index : xy_off;

  pag_scale_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_scale (
    .base       (in_base),
    .offset     (sel_off),
    .byte_shift (byte_shift),
    .addr       (next_addr)
  );

  pag_out_stage #(.W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (in_valid),
    .acc_ready (in_ready),
    .d         (next_addr),
    .q_valid   (out_valid),
    .q_ready   (out_ready),
    .q         (out_addr)
  );
endmodule

// File: tb/pix_addr_gen_tb_top.sv
module pix_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_xbits = 8'd9, cfg_ybits = 8'd8;
  logic [3:0]  cfg_bpp = 4'd2;
  logic        cfg_seq = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_base = '0;
  logic [15:0] in_x = '0, in_y = '0;
  logic [31:0] in_index = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit rnd_ready = 1'b0;
  bit burst_mode = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          prev_acc = 1'b0, prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  always #4 clk = ~clk;

  pix_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_xbits(cfg_xbits), .cfg_ybits(cfg_ybits),
    .cfg_bpp(cfg_bpp), .cfg_seq(cfg_seq), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_x(in_x), .in_y(in_y), .in_index(in_index),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  function automatic logic [31:0] model(input logic [31:0] base, input logic [15:0] x,
      input logic [15:0] y, input logic [31:0] idx, input logic [7:0] n, input logic [7:0] m,
      input logic [3:0] b, input bit seq);
    longint unsigned bytes, lin, xm, ym;
    int nn, mm;
    bytes = (b <= 4'd1) ? 1 : (b == 4'd2) ? 2 : 4;
    nn = (n > 8'd16) ? 16 : int'(n);
    mm = (m > 8'd16) ? 16 : int'(m);
    if (seq) lin = longint'(idx);
    else begin
      xm  = longint'(x) & ((64'd1 << nn) - 1);
      ym  = longint'(y) & ((64'd1 << mm) - 1);
      lin = (ym << nn) | xm;
    end
    return 32'(longint'(base) + lin * bytes);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rnd_ready) out_ready = ($urandom % 4) != 0;
    else out_ready = 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_acc) check(out_valid, "R6", 32'(out_valid), 32'd1);
      if (prev_stall) check(out_valid && out_addr == prev_addr, "R7", out_addr, prev_addr);
      if (out_valid && !out_ready) check(!in_ready, "R7", 32'(in_ready), 32'd0);
      if (burst_mode && in_valid) check(in_ready, "R6", 32'(in_ready), 32'd1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R6", out_addr, 32'hx);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_addr == e, t, out_addr, e);
        end
      end
      prev_acc = in_valid && in_ready;
      if (prev_acc) begin
        exp_q.push_back(model(in_base, in_x, in_y, in_index, cfg_xbits, cfg_ybits, cfg_bpp, cfg_seq));
        tag_q.push_back(cur_tag);
      end
      prev_stall = out_valid && !out_ready;
      prev_addr  = out_addr;
    end
  end

  string cur_tag = "R2";

  task automatic send(input logic [31:0] base, input logic [15:0] x, input logic [15:0] y,
      input logic [31:0] idx, input logic [7:0] n, input logic [7:0] m, input logic [3:0] b,
      input bit seq, input string tag);
    @(negedge clk);
    in_base = base; in_x = x; in_y = y; in_index = idx;
    cfg_xbits = n; cfg_ybits = m; cfg_bpp = b; cfg_seq = seq;
    cur_tag = tag; in_valid = 1'b1;
    forever begin
      #3;
      if (in_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R1", {30'd0, out_valid, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R10 worked example and frame end
    send(32'h0800_0000, 16'd250, 16'd110, 0, 8'd9, 8'd8, 4'd2, 1'b0, "R10");
    send(32'h0800_0000, 16'd511, 16'd255, 0, 8'd9, 8'd8, 4'd2, 1'b0, "R10");
    // R3 high bits ignored
    send(32'h1000_0000, 16'hFFFF, 16'hFF05, 0, 8'd9, 8'd8, 4'd2, 1'b0, "R3");
    send(32'h1000_0000, 16'h0E03, 16'h7001, 0, 8'd4, 8'd3, 4'd1, 1'b0, "R3");
    // R5 every pixel-size code
    for (int b = 0; b < 16; b++)
      send(32'h0000_1000, 16'd3, 16'd2, 0, 8'd4, 8'd4, 4'(b), 1'b0, "R5");
    // R4 linear mode, coordinates ignored
    send(32'h0200_0000, 16'hFFFF, 16'hFFFF, 32'd1000, 8'd9, 8'd8, 4'd2, 1'b1, "R4");
    send(32'h0200_0000, 16'h1234, 16'h0, 32'h00FF_FFFF, 8'd0, 8'd0, 4'd3, 1'b1, "R4");
    // R8 clamp and zero width
    send(32'h0, 16'hABCD, 16'h1234, 0, 8'd20, 8'd200, 4'd1, 1'b0, "R8");
    send(32'h0, 16'hABCD, 16'h1234, 0, 8'd0, 8'd5, 4'd1, 1'b0, "R8");
    send(32'h0, 16'hABCD, 16'h1234, 0, 8'd7, 8'd0, 4'd1, 1'b0, "R8");
    // R9 wrap
    send(32'hFFFF_FFF0, 16'd10, 16'd0, 0, 8'd8, 8'd8, 4'd4, 1'b0, "R9");
    send(32'hFFFF_0000, 16'd0, 16'd0, 32'h8000_0000, 8'd8, 8'd8, 4'd2, 1'b1, "R9");
    idle(4);
    // R6 back-to-back at full rate
    burst_mode = 1'b1;
    for (int i = 0; i < 16; i++)
      send(32'h0400_0000 + 32'(i), 16'(i * 7), 16'(i), 0, 8'd9, 8'd8, 4'd2, 1'b0, "R6");
    idle(4);
    burst_mode = 1'b0;
    // R7 random back-pressure with random traffic
    rnd_ready = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] n, m;
      n = 8'($urandom % 20);
      m = 8'($urandom % 20);
      send($urandom, 16'($urandom), 16'($urandom), $urandom, n, m, 4'($urandom),
           ($urandom % 3) == 0, (i % 2 == 0) ? "R2" : "R7");
      if (($urandom % 8) == 0) idle($urandom % 3);
    end
    idle(2);
    rnd_ready = 1'b0;
    idle(6);
    check(exp_q.size() == 0, "R6", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule